// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block classifies every memory access that falls in the compatibility area below 1 MB. For each access it decides whether the access goes to DRAM for reads and writes, to DRAM for reads only, or to the PCI bus. A set of byte-wide configuration registers drives this decision, together with a system-management-mode (SMM) input. The result is a registered target code and a write-suppress flag. A write that hits a read-only segment is claimed by no one and is flagged.

Three kinds of window are decoded. The first is a run of twelve 16 KB segments starting at C0000. The second is one 64 KB segment at F0000. The third is the A0000–BFFFF graphics/SMRAM window, which opens to DRAM either through an enable bit qualified by SMM or through an unconditional open bit. Any other address, whether below A0000 or at or above 1 MB, goes to DRAM read/write. The block also reports the installed memory size in 8 MB units. This value is derived from a build parameter.

Top module: `lmad_top`

## Requirements
- R1: After reset, resp_valid is 0 and every attribute field is 0. Register 0x72 holds 0x02, so C0000–FFFFF and A0000–BFFFF all resolve to PCI whatever the SMM input is.
- R2: resp_tgt encodes 2'b00 = DRAM, 2'b01 = PCI, 2'b10 = none. 2'b11 never appears. Attribute 3 gives DRAM for reads and writes, attribute 1 gives DRAM for reads, and attributes 0 and 2 give PCI.
- R3: A write to a segment whose attribute is 1 returns resp_tgt = 2'b10 with resp_wr_block = 1. Every other result has resp_wr_block = 0.
- R4: The 64 KB segment F0000–FFFFF takes its attribute from register 0x59 bits [5:4]. The other bits of 0x59 have no effect.
- R5: 16 KB segment i (0..11) covers C0000 + i*0x4000 to C0000 + (i+1)*0x4000 - 1. Its attribute is in register 0x5A + (i>>1), bits [1:0] for even i and bits [5:4] for odd i.
- R6: A0000–BFFFF resolves to DRAM read/write when (smm_active AND register 0x72 bit 3) OR register 0x72 bit 6. Otherwise it resolves to PCI.
- R7: Addresses below A0000, and addresses at or above 0x100000, resolve to DRAM read/write.
- R8: Each cycle with acc_valid = 1 yields exactly one result, with resp_valid = 1 on the next cycle. That result reflects every configuration write made in an earlier cycle and the smm_active value of the access cycle.
- R9: Configuration writes to offsets outside 0x59–0x5F and 0x72 leave all routing unchanged.
- R10: mem_size_units equals MEM_SIZE_MB/8, saturated at 255. It reads 64 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| smm_active | input | 1 | System-management mode is active |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| resp_valid | output | 1 | Result valid, one cycle after acc_valid |
| resp_tgt | output | 2 | Target code: 00 DRAM, 01 PCI, 10 none |
| resp_wr_block | output | 1 | Write suppressed on a read-only segment |
| mem_size_units | output | 8 | Installed memory in 8 MB units, saturated |

## Verification
A result is due exactly one clock edge after the cycle in which acc_valid is sampled high. A configuration write takes effect for any access sampled on a later edge, while smm_active acts in the same cycle as its access. The bench drives each stimulus just after a falling edge. A monitor looks at the outputs on the following falling edge, where the one-edge result has settled, and pops the oldest expected item from the scoreboard queue. One sequence places a configuration write and an access on consecutive edges, which checks the earliest point at which the new value is used. Any result that arrives with no queued item, and any item still queued at the end, counts as a failure.

// File: rtl/lmad_pkg.sv
// Shared types and constants for the legacy memory attribute decoder.
// Assumes an 8-bit configuration offset space.
package lmad_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'b00,
        TGT_PCI  = 2'b01,
        TGT_NONE = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        WIN_PLAIN = 2'd0,
        WIN_SMRAM = 2'd1,
        WIN_SEG16 = 2'd2,
        WIN_SEG64 = 2'd3
    } win_e;

    localparam logic [1:0] ATTR_RO = 2'd1;
    localparam logic [1:0] ATTR_RW = 2'd3;

    localparam logic [7:0] CFG_UPPER_OFF  = 8'h59;
    localparam logic [7:0] CFG_SEG_BASE   = 8'h5A;
    localparam logic [7:0] CFG_SMRAM_OFF  = 8'h72;
    localparam logic [7:0] SMRAM_RST_VAL  = 8'h02;
    localparam int         SMRAM_SMM_BIT  = 3;
    localparam int         SMRAM_OPEN_BIT = 6;

    localparam logic [19:0] SMRAM_LO  = 20'hA0000;
    localparam logic [19:0] SEG16_LO  = 20'hC0000;
    localparam logic [19:0] SEG64_LO  = 20'hF0000;
    localparam int          SEG16_SHIFT = 14;

endpackage

// File: rtl/lmad_attr_regs.sv
// Attribute register file: the upper-segment byte, the packed 16 KB
// segment bytes (two 2-bit fields per byte, in bits [1:0] and [5:4]) and
// the SMRAM control byte. Assumes NUM_SEG16 <= 12 so offsets stay below 0x60.
module lmad_attr_regs
    import lmad_pkg::*;
#(
    parameter int NUM_SEG16 = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr_en,
    input  logic [7:0]                cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [NUM_SEG16-1:0][1:0] seg_attr,
    output logic [1:0]                upper_attr,
    output logic                      smram_smm_en,
    output logic                      smram_open
);
    localparam int NBYTES = (NUM_SEG16 + 1) / 2;

    logic [7:0] upper_q;
    logic [7:0] smram_q;
    logic [NBYTES-1:0][7:0] seg_q;

    // Upper 64 KB segment attribute byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upper_q <= 8'h00;
        else if (cfg_wr_en && cfg_addr == CFG_UPPER_OFF)
            upper_q <= cfg_wdata;
    end

    // SMRAM control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smram_q <= SMRAM_RST_VAL;
        else if (cfg_wr_en && cfg_addr == CFG_SMRAM_OFF)
            smram_q <= cfg_wdata;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_seg_byte
        localparam logic [7:0] OFF = CFG_SEG_BASE + 8'(b);
        // One packed byte holding two 16 KB segment attributes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[b] <= 8'h00;
            else if (cfg_wr_en && cfg_addr == OFF)
                seg_q[b] <= cfg_wdata;
        end
        logic unused_seg_bits;
        assign unused_seg_bits = ^{seg_q[b][7:6], seg_q[b][3:2]};
    end

    for (genvar s = 0; s < NUM_SEG16; s++) begin : g_seg_field
        if (s % 2 == 1) begin : g_odd
            assign seg_attr[s] = seg_q[s/2][5:4];
        end else begin : g_even
            assign seg_attr[s] = seg_q[s/2][1:0];
        end
    end

    if (NUM_SEG16 % 2 == 1) begin : g_pad
        logic unused_pad_bits;
        assign unused_pad_bits = ^seg_q[NBYTES-1][5:4];
    end

    assign upper_attr   = upper_q[5:4];
    assign smram_smm_en = smram_q[SMRAM_SMM_BIT];
    assign smram_open   = smram_q[SMRAM_OPEN_BIT];

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{upper_q[7:6], upper_q[3:0],
                               smram_q[7], smram_q[5:4], smram_q[2:0]};

endmodule

// File: rtl/lmad_win_decode.sv
// Address window decoder: sorts an address into the plain region, the
// SMRAM window, a 16 KB segment (with its index) or the 64 KB segment.
// Assumes ADDR_W >= 20; any set bit at or above bit 20 is outside 1 MB.
module lmad_win_decode
    import lmad_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SEG16 = 12,
    localparam int IDX_W    = (NUM_SEG16 > 1) ? $clog2(NUM_SEG16) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  seg_idx
);
    logic        above_1m;
    logic [19:0] low20;
    logic [5:0]  idx_full;

    if (ADDR_W > 20) begin : g_wide
        assign above_1m = |addr[ADDR_W-1:20];
    end else begin : g_narrow
        assign above_1m = 1'b0;
    end

    assign low20    = addr[19:0];
    assign idx_full = low20[19:SEG16_SHIFT] - SEG16_LO[19:SEG16_SHIFT];

    // Pick the window that contains the address.
    always_comb begin
        win     = WIN_PLAIN;
        seg_idx = IDX_W'(idx_full);
        if (above_1m || low20 < SMRAM_LO)
            win = WIN_PLAIN;
        else if (low20 < SEG16_LO)
            win = WIN_SMRAM;
        else if (low20 >= SEG64_LO)
            win = WIN_SEG64;
        else if (idx_full < 6'(NUM_SEG16))
            win = WIN_SEG16;
        else
            win = WIN_PLAIN;
    end

endmodule

// File: rtl/lmad_route.sv
// Routing logic: turns the decoded window, the attribute fields, the
// SMRAM control bits, SMM and the access direction into a target code
// and a write-suppress flag. Purely combinational.
module lmad_route
    import lmad_pkg::*;
#(
    parameter int NUM_SEG16 = 12,
    localparam int IDX_W    = (NUM_SEG16 > 1) ? $clog2(NUM_SEG16) : 1
) (
    input  win_e                      win,
    input  logic [IDX_W-1:0]          seg_idx,
    input  logic [NUM_SEG16-1:0][1:0] seg_attr,
    input  logic [1:0]                upper_attr,
    input  logic                      smram_smm_en,
    input  logic                      smram_open,
    input  logic                      smm_active,
    input  logic                      is_write,
    output tgt_e                      tgt,
    output logic                      wr_block
);
    logic [1:0] attr;
    logic       smram_to_dram;

    // Select the attribute field of the addressed segment.
    always_comb begin
        attr = 2'd0;
        if (win == WIN_SEG64)
            attr = upper_attr;
        else if (seg_idx < IDX_W'(NUM_SEG16))
            attr = seg_attr[seg_idx];
    end

    assign smram_to_dram = (smm_active && smram_smm_en) || smram_open;

    // Map window and attribute to the target.
    always_comb begin
        tgt      = TGT_DRAM;
        wr_block = 1'b0;
        unique case (win)
            WIN_PLAIN: tgt = TGT_DRAM;
            WIN_SMRAM: tgt = smram_to_dram ? TGT_DRAM : TGT_PCI;
            WIN_SEG16, WIN_SEG64: begin
                if (attr == ATTR_RW) begin
                    tgt = TGT_DRAM;
                end else if (attr == ATTR_RO) begin
                    tgt      = is_write ? TGT_NONE : TGT_DRAM;
                    wr_block = is_write;
                end else begin
                    tgt = TGT_PCI;
                end
            end
            default: tgt = TGT_DRAM;
        endcase
    end

endmodule

// File: rtl/lmad_top.sv
// Legacy memory attribute decoder top: register file, window decode and
// routing, with one output register stage. A result appears one cycle
// after its access; configuration writes act from the following cycle.
module lmad_top
    import lmad_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MEM_SIZE_MB = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              smm_active,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              resp_valid,
    output logic [1:0]        resp_tgt,
    output logic              resp_wr_block,
    output logic [7:0]        mem_size_units
);
    localparam int NUM_SEG16 = 12;
    localparam int IDX_W     = $clog2(NUM_SEG16);
    localparam int MEM_RAW   = MEM_SIZE_MB / 8;
    localparam int MEM_UNITS = (MEM_RAW > 255) ? 255 : MEM_RAW;

    logic [NUM_SEG16-1:0][1:0] seg_attr;
    logic [1:0]                upper_attr;
    logic                      smram_smm_en;
    logic                      smram_open;
    win_e                      win;
    logic [IDX_W-1:0]          seg_idx;
    tgt_e                      tgt;
    logic                      wr_block;

    tgt_e resp_tgt_q;
    logic resp_valid_q;
    logic resp_blk_q;

    lmad_attr_regs #(.NUM_SEG16(NUM_SEG16)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .seg_attr     (seg_attr),
        .upper_attr   (upper_attr),
        .smram_smm_en (smram_smm_en),
        .smram_open   (smram_open)
    );

    lmad_win_decode #(.ADDR_W(ADDR_W), .NUM_SEG16(NUM_SEG16)) u_dec (
        .addr    (acc_addr),
        .win     (win),
        .seg_idx (seg_idx)
    );

    lmad_route #(.NUM_SEG16(NUM_SEG16)) u_route (
        .win          (win),
        .seg_idx      (seg_idx),
        .seg_attr     (seg_attr),
        .upper_attr   (upper_attr),
        .smram_smm_en (smram_smm_en),
        .smram_open   (smram_open),
        .smm_active   (smm_active),
        .is_write     (acc_write),
        .tgt          (tgt),
        .wr_block     (wr_block)
    );

    // Register the routing result of each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_tgt_q   <= TGT_DRAM;
            resp_blk_q   <= 1'b0;
        end else begin
            resp_valid_q <= acc_valid;
            resp_blk_q   <= acc_valid && wr_block;
            if (acc_valid)
                resp_tgt_q <= tgt;
        end
    end

    assign resp_valid     = resp_valid_q;
    assign resp_tgt       = resp_tgt_q;
    assign resp_wr_block  = resp_blk_q;
    assign mem_size_units = 8'(MEM_UNITS);

endmodule

// File: rtl/lmad_chk.sv
// Property checker for lmad_top, attached by bind. Observes the access
// ports, the result ports and the SMRAM control bits from the register file.
module lmad_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              smm_active,
    input logic              resp_valid,
    input logic [1:0]        resp_tgt,
    input logic              resp_wr_block,
    input logic              smram_smm_en,
    input logic              smram_open
);
    logic in_smram;
    logic low_plain;
    assign in_smram  = (acc_addr >= ADDR_W'('hA0000)) && (acc_addr < ADDR_W'('hC0000));
    assign low_plain = acc_addr < ADDR_W'('hA0000);

    p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);
    p_block_is_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_wr_block |-> resp_tgt == 2'b10);
    p_read_never_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> resp_tgt != 2'b10 && !resp_wr_block);
    p_low_dram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && low_plain |=> resp_tgt == 2'b00 && !resp_wr_block);
    p_smram_dram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_smram && (smram_open || (smm_active && smram_smm_en))
        |=> resp_tgt == 2'b00);
    p_smram_pci_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_smram && !smram_open && !(smm_active && smram_smm_en)
        |=> resp_tgt == 2'b01);
    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_tgt != 2'b11);

endmodule

bind lmad_top lmad_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_addr      (acc_addr),
    .acc_write     (acc_write),
    .smm_active    (smm_active),
    .resp_valid    (resp_valid),
    .resp_tgt      (resp_tgt),
    .resp_wr_block (resp_wr_block),
    .smram_smm_en  (smram_smm_en),
    .smram_open    (smram_open)
);

// File: tb/lmad_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench for lmad_top: driver tasks queue expected results,
// a falling-edge monitor pops and compares them.
module lmad_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        smm_active = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        resp_valid;
    logic [1:0]  resp_tgt;
    logic        resp_wr_block;
    logic [7:0]  mem_size_units;

    always #2 clk = ~clk;

    lmad_top uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .smm_active(smm_active), .cfg_wr_en(cfg_wr_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .resp_valid(resp_valid),
        .resp_tgt(resp_tgt), .resp_wr_block(resp_wr_block),
        .mem_size_units(mem_size_units)
    );

    typedef struct {
        logic [1:0] tgt;
        logic       blk;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails = 0;
    logic [7:0] shadow [256];
    bit         done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected {target, block} from the requirements and the shadow registers.
    function automatic logic [2:0] model(input logic [31:0] a, input bit wr, input bit smm);
        logic [1:0] at;
        int idx;
        if (a >= 32'h100000 || a < 32'hA0000) return 3'b000;
        if (a < 32'hC0000)
            return ((smm && shadow[8'h72][3]) || shadow[8'h72][6]) ? 3'b000 : 3'b010;
        if (a >= 32'hF0000) begin
            at = shadow[8'h59][5:4];
        end else begin
            idx = int'((a - 32'hC0000) >> 14);
            at  = (idx % 2 == 1) ? shadow[8'h5A + idx/2][5:4] : shadow[8'h5A + idx/2][1:0];
        end
        if (at == 2'd3) return 3'b000;
        if (at == 2'd1) return wr ? 3'b101 : 3'b000;
        return 3'b010;
    endfunction

    task automatic push_exp(input logic [31:0] a, input bit wr, input bit smm, input string tag);
        logic [2:0] m;
        exp_t e;
        m = model(a, wr, smm);
        e.tgt = m[2:1];
        e.blk = m[0];
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input bit smm, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; smm_active = smm;
        push_exp(a, wr, smm, tag);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = data;
        shadow[off] = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Config write on one edge, access on the very next edge.
    task automatic cfg_then_access(input logic [7:0] off, input logic [7:0] data,
                                   input logic [31:0] a, input bit wr, input string tag);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = data;
        shadow[off] = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        push_exp(a, wr, smm_active, tag);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Monitor: compare each result against the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 result without access", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(resp_tgt == e.tgt, {e.tag, " target"}, int'(resp_tgt), int'(e.tgt));
                check(resp_wr_block == e.blk, {e.tag, " wr_block"}, int'(resp_wr_block), int'(e.blk));
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
        shadow[8'h72] = 8'h02;
        repeat (4) @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid in reset", int'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);
        check(mem_size_units == 8'd64, "R10 mem_size_units", int'(mem_size_units), 64);

        // R1: reset routing
        access(32'h000C0000, 1'b0, 1'b0, "R1 C0000 read");
        access(32'h000F0000, 1'b1, 1'b0, "R1 F0000 write");
        access(32'h000EC000, 1'b0, 1'b0, "R1 EC000 read");
        access(32'h000A0000, 1'b0, 1'b1, "R1 A0000 with SMM");

        // R7: plain regions
        access(32'h00000000, 1'b1, 1'b0, "R7 zero write");
        access(32'h0009FFFF, 1'b1, 1'b0, "R7 9FFFF write");
        access(32'h00100000, 1'b1, 1'b0, "R7 above 1MB");
        access(32'h800F0000, 1'b0, 1'b0, "R7 high alias");

        // R4: upper segment
        cfg_wr(8'h59, 8'h30);
        access(32'h000F0000, 1'b1, 1'b0, "R4 F0000 rw write");
        access(32'h000FFFFF, 1'b0, 1'b0, "R4 FFFFF rw read");
        cfg_wr(8'h59, 8'hCF);
        access(32'h000F8000, 1'b0, 1'b0, "R4 other bits ignored");
        cfg_wr(8'h59, 8'h10);
        access(32'h000F4000, 1'b1, 1'b0, "R4 R3 F0000 ro write");

        // R5 / R2 / R3: packed 16 KB fields
        cfg_wr(8'h5A, 8'h31);
        access(32'h000C0000, 1'b1, 1'b0, "R3 seg0 ro write");
        access(32'h000C3FFF, 1'b0, 1'b0, "R3 seg0 ro read");
        access(32'h000C4000, 1'b1, 1'b0, "R5 seg1 rw write");
        access(32'h000C8000, 1'b0, 1'b0, "R5 seg2 still pci");
        cfg_wr(8'h5F, 8'h21);
        access(32'h000E8000, 1'b1, 1'b0, "R5 seg10 ro write");
        access(32'h000EC000, 1'b1, 1'b0, "R2 seg11 attr2 pci");
        access(32'h000EFFFF, 1'b0, 1'b0, "R2 seg11 end read");
        cfg_wr(8'h5C, 8'h13);
        access(32'h000D0000, 1'b1, 1'b0, "R5 seg4 rw");
        access(32'h000D7FFF, 1'b1, 1'b0, "R5 seg5 ro write");
        access(32'h000D8000, 1'b0, 1'b0, "R5 seg6 pci");
        cfg_wr(8'h5B, 8'h02);
        access(32'h000C8000, 1'b1, 1'b0, "R2 seg2 attr2");

        // R9: other offsets leave routing alone
        cfg_wr(8'h58, 8'hFF);
        cfg_wr(8'h60, 8'hFF);
        cfg_wr(8'h71, 8'hFF);
        cfg_wr(8'h73, 8'hFF);
        access(32'h000C0000, 1'b1, 1'b0, "R9 seg0 unchanged");
        access(32'h000CC000, 1'b0, 1'b0, "R9 seg3 unchanged");
        access(32'h000B0000, 1'b0, 1'b1, "R9 smram unchanged");

        // R6: SMRAM window
        cfg_wr(8'h72, 8'h0A);
        access(32'h000A0000, 1'b1, 1'b0, "R6 en no smm");
        access(32'h000A0000, 1'b1, 1'b1, "R6 en with smm");
        access(32'h000BFFFF, 1'b0, 1'b1, "R6 top with smm");
        access(32'h000BFFFF, 1'b0, 1'b0, "R6 smm dropped");
        cfg_wr(8'h72, 8'h42);
        access(32'h000A8000, 1'b1, 1'b0, "R6 open bit");
        cfg_wr(8'h72, 8'h02);
        access(32'h000A8000, 1'b1, 1'b1, "R6 closed");

        // R8: config written on the edge before the access
        cfg_then_access(8'h5E, 8'h03, 32'h000E0000, 1'b1, "R8 new attr next edge");
        cfg_then_access(8'h72, 8'h40, 32'h000A0000, 1'b0, "R8 new smram next edge");
        // R8: back-to-back accesses
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h000C0000; acc_write = 1'b1;
        push_exp(32'h000C0000, 1'b1, smm_active, "R8 burst 1");
        @(negedge clk);
        acc_addr = 32'h000C4000; acc_write = 1'b1;
        push_exp(32'h000C4000, 1'b1, smm_active, "R8 burst 2");
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R8 pending results", sb.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule